// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus on which a target device has been left holding the data line low, for example after a reset in the middle of a read. On a start request it takes the clock and data lines away from the normal bus engine. It does this through two open-drain pull-low enables, where an asserted enable forces the line low and a deasserted one lets the pull-up raise it. It then clocks the bus nine times, so that any target part-way through a byte can shift out its remaining bits and release the data line. After the pulses it produces a STOP condition: both lines low, then the clock released, then the data released while the clock is high.

Every step of the sequence lasts one dwell period of equal length. That length is `CYC_PER_US * DWELL_US` clock cycles, with a default of 5 microseconds. The whole sequence is 21 dwells long. While it runs, `busy` is high. When it finishes, `done` pulses for one cycle. Outside the sequence both enables stay low, so the normal engine keeps the lines. Deciding when the bus is stuck is left to the caller, and so are ordinary transfers.

All pins are plain control and status signals. There is no data stream and no handshake, and `start` is a level that is sampled on each clock.

Top module: `scl_recovery_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `scl_pull` and `sda_pull` are all 0.
- R2: When `start` is sampled high while idle, `busy` rises on that edge and stays high for exactly 21 dwell periods.
- R3: The first 18 dwells form nine clock pulses. The even-numbered dwells (0, 2, … 16) have both enables low. The odd-numbered dwells (1, 3, … 17) have only `scl_pull` high. `sda_pull` stays low throughout these 18 dwells.
- R4: A dwell period is exactly `CYC_PER_US * DWELL_US` clock cycles, and the enables change only at dwell boundaries.
- R5: Dwell 18 has both `scl_pull` and `sda_pull` high.
- R6: Dwell 19 has `scl_pull` low and `sda_pull` high. Dwell 20 has both enables low, so the data line rises while the clock is released.
- R7: A `start` sampled high while `busy` is high has no effect on the sequence.
- R8: `done` is high for exactly one cycle. That cycle is the one that follows the end of dwell 20, and `busy` is already low in it.
- R9: Whenever `busy` is low, both `scl_pull` and `sda_pull` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the recovery sequence, sampled each clock |
| busy | output | 1 | High while the sequence owns the bus lines |
| done | output | 1 | One-cycle pulse when the sequence completes |
| scl_pull | output | 1 | Open-drain enable that pulls the clock line low |
| sda_pull | output | 1 | Open-drain enable that pulls the data line low |

## Verification
The assertions assume that reset drops the block back to idle at any moment, even mid-sequence, and that `start` may be held or toggled freely in any cycle. They assume nothing about the bus itself, because the block never reads the lines. The stimulus drives `start` from a seeded random draw at varied densities. It includes stretches where `start` is held high across whole sequences and a request that lands in the same cycle as `done`. It also includes one reset asserted mid-sequence, so that the abort path and the ignore-while-busy path both fall inside the assumed input space.

// File: rtl/scl_rec_pkg.sv
package scl_rec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_RELEASE  = 3'd1,
    PH_SCL_LOW  = 3'd2,
    PH_BOTH_LOW = 3'd3,
    PH_SDA_LOW  = 3'd4,
    PH_FINAL    = 3'd5
  } phase_e;
endpackage

// File: rtl/rec_dwell_timer.sv
module rec_dwell_timer #(
  parameter int DWELL = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DWELL < 2) ? 1 : $clog2(DWELL);
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R4
endmodule

// File: rtl/rec_pulse_count.sv
module rec_pulse_count #(
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic [$clog2(PULSES+1)-1:0] count,
  output logic last
);
  localparam int W = $clog2(PULSES + 1);

  assign last = (count == W'(PULSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= count + 1'b1;
  end

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= W'(PULSES));  // R3
endmodule

// File: rtl/rec_phase_fsm.sv
module rec_phase_fsm
  import scl_rec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   tick,
  input  logic   last_pulse,
  output phase_e phase,
  output logic   done
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:     if (start) nxt = PH_RELEASE;
      PH_RELEASE:  if (tick)  nxt = PH_SCL_LOW;
      PH_SCL_LOW:  if (tick)  nxt = last_pulse ? PH_BOTH_LOW : PH_RELEASE;
      PH_BOTH_LOW: if (tick)  nxt = PH_SDA_LOW;
      PH_SDA_LOW:  if (tick)  nxt = PH_FINAL;
      PH_FINAL:    if (tick)  nxt = PH_IDLE;
      default:                nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      done  <= (phase == PH_FINAL) && tick;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !tick) |=> $stable(phase));  // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase != PH_IDLE && !tick) |=> (phase != PH_IDLE));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
endmodule

// File: rtl/scl_recovery_seq.sv
module scl_recovery_seq
  import scl_rec_pkg::*;
#(
  parameter int CYC_PER_US = 2,
  parameter int DWELL_US   = 5,
  parameter int PULSES     = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic scl_pull,
  output logic sda_pull
);
  localparam int DWELL = CYC_PER_US * DWELL_US;
  localparam int PW    = $clog2(PULSES + 1);

  phase_e          phase;
  logic            tick;
  logic            last_pulse;
  logic [PW-1:0]   pulse_cnt;

  rec_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  rec_pulse_count #(.PULSES(PULSES)) u_pulses (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(phase == PH_IDLE),
    .bump ((phase == PH_SCL_LOW) && tick),
    .count(pulse_cnt),
    .last (last_pulse)
  );

  rec_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (tick),
    .last_pulse(last_pulse),
    .phase     (phase),
    .done      (done)
  );

  assign busy     = (phase != PH_IDLE);
  assign scl_pull = (phase == PH_SCL_LOW) || (phase == PH_BOTH_LOW);
  assign sda_pull = (phase == PH_BOTH_LOW) || (phase == PH_SDA_LOW);

  AST_SDA_FREE_CLOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pulse_cnt < PW'(PULSES)) |-> !sda_pull);  // R3
  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !scl_pull && !sda_pull));  // R8
endmodule

// File: tb/sim_scl_recovery_seq.sv
`timescale 1ns/1ps
module sim_scl_recovery_seq;
  localparam int CPU   = 2;
  localparam int DUS   = 5;
  localparam int D     = CPU * DUS;
  localparam int TOTAL = 21 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, scl_pull, sda_pull;

  int vectors = 0;
  int errors  = 0;
  int ref_t   = -1;
  bit exp_done = 1'b0;

  always #4 clk = ~clk;

  scl_recovery_seq #(.CYC_PER_US(CPU), .DWELL_US(DUS), .PULSES(9)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  function automatic bit exp_scl(int t);
    int i = t / D;
    if (t < 0) return 1'b0;
    if (i < 18) return (i % 2) == 1;
    return i == 18;
  endfunction

  function automatic bit exp_sda(int t);
    int i = t / D;
    if (t < 0) return 1'b0;
    return (i == 18) || (i == 19);
  endfunction

  function automatic string tag_of(int t);
    int i = t / D;
    if (t < 0) return "R9";
    if (i < 18) return "R3";
    if (i == 18) return "R5";
    return "R6";
  endfunction

  task automatic check_bit(string what, string req, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %0b expected %0b", req, what, $time, act, exp);
    end
  endtask

  task automatic check_all(string req_busy);
    check_bit("busy", req_busy, busy, ref_t >= 0);
    check_bit("done", "R8", done, exp_done);
    check_bit("scl_pull", tag_of(ref_t), scl_pull, exp_scl(ref_t));
    check_bit("sda_pull", tag_of(ref_t), sda_pull, exp_sda(ref_t));
  endtask

  // apply start for the coming edge and advance the reference model
  task automatic step(bit s);
    start = s;
    @(posedge clk);
    if (ref_t < 0) begin
      exp_done = 1'b0;
      if (s) ref_t = 0;
    end else begin
      ref_t++;
      if (ref_t == TOTAL) begin
        ref_t = -1;
        exp_done = 1'b1;
      end else begin
        exp_done = 1'b0;
      end
    end
    @(negedge clk);
    check_all((ref_t >= 0 && s) ? "R7" : "R2");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 R4 R8: a single isolated sequence, start for one cycle
    step(1'b1);
    for (int k = 0; k < TOTAL + 5; k++) step(1'b0);

    // R7: start held high across two full sequences
    for (int k = 0; k < 2 * TOTAL + 4; k++) step(1'b1);

    // start arriving in the same cycle as done
    for (int k = 0; k < TOTAL + 3; k++) step(ref_t == TOTAL - 1 ? 1'b1 : (k == 0));
    for (int k = 0; k < TOTAL + 5; k++) step(done);

    // R1 R9: reset asserted in the middle of a sequence
    step(1'b1);
    for (int k = 0; k < 19 * D + 3; k++) step(1'b0);
    rst_n = 1'b0;
    ref_t = -1;
    exp_done = 1'b0;
    #1;
    check_all("R1");
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b0);

    // random start density phases
    for (int k = 0; k < 4000; k++) begin
      int dens = (k < 1500) ? 40 : ((k < 3000) ? 4 : 1);
      step(($urandom % dens) == 0);
    end
    for (int k = 0; k < TOTAL + 2; k++) step(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule